// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block collects thirteen event pulses from a serial port's transmit, receive and modem logic and turns them into a single level interrupt request. Each event sets a sticky status bit. A mask decides which status bits may raise the interrupt. Software never writes the mask directly. It turns mask bits on through a set-only register and turns them off through a clear-only register, so two agents can change different bits without a read-modify-write race.

Software reads the mask and the status through a single-cycle register port. It acknowledges events by writing ones to the status register. Status bits record events whether or not they are masked, so software can poll a masked source and acknowledge it later. Writing all thirteen ones first to the clear-only mask register and then to the status register leaves the block quiet.

Top module: `sirq_bank`

## Requirements
- R1: While reset is asserted, and at release, the mask is 0x0000, the status is 0x0000 and `irq` is low.
- R2: A write to offset 0x08 sets every mask bit whose write-data bit is 1. Mask bits written with 0 keep their value.
- R3: A write to offset 0x0C clears every mask bit whose write-data bit is 1. Mask bits written with 0 keep their value.
- R4: Reads are combinational. Offset 0x10 returns the mask and offset 0x14 returns the status, both in bits 12:0. Bits 31:13 read as zero. Offsets 0x08, 0x0C and any unmapped offset read as zero.
- R5: An `evt_pulse[i]` sampled high at a clock edge sets status bit i at that edge, whether or not mask bit i is set. Bit i then stays set until software clears it. The sources are: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem status change, 10 transmit trigger, 11 transmit nearly full, 12 transmit overflow.
- R6: A write to offset 0x14 clears every status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R7: If an event pulse and a status clear reach the same bit in the same cycle, the bit ends up set.
- R8: `irq` is a register. In each cycle it holds the OR over all bits of (status AND mask) as that value stood in the previous cycle.
- R9: Writes to offset 0x10 and to unmapped offsets change neither the mask nor the status. Write-data bits 31:13 have no effect at any offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_addr | input | 8 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_pulse | input | 13 | One-cycle event pulses, one per source |
| irq | output | 1 | Registered level interrupt request |

## Verification
Two functions can hit the same status bit in the same cycle: a hardware event pulse, and a software write-one-to-clear through the port. The bench first sets a status bit. It then drives the pulse for that bit together with a status write that has a 1 in the same position. On the following read of the status, the bit must still be set while the other cleared bits are gone. A reference model in the bench applies the set-over-clear rule by itself and predicts both the read value and the `irq` level.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned SRC_COUNT = 13;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned OFFS_W    = 8;

  localparam logic [7:0] OFFS_SET_MASK = 8'h08;
  localparam logic [7:0] OFFS_CLR_MASK = 8'h0C;
  localparam logic [7:0] OFFS_MASK_RD  = 8'h10;
  localparam logic [7:0] OFFS_STATUS   = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SET_MASK,
    SEL_CLR_MASK,
    SEL_MASK_RD,
    SEL_STATUS
  } reg_sel_e;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_COUNT,
  parameter int unsigned ADDR_W = OFFS_W,
  parameter int unsigned DATA_W = BUS_W
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output reg_sel_e          sel,
  output logic [N_SRC-1:0]  set_mask_bits,
  output logic [N_SRC-1:0]  clr_mask_bits,
  output logic [N_SRC-1:0]  clr_stat_bits
);

  localparam int unsigned HI_W = DATA_W - N_SRC;

  logic [N_SRC-1:0] wbits;
  logic             unused_wdata_hi;

  assign wbits           = reg_wdata[N_SRC-1:0];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:DATA_W-HI_W];

  always_comb begin
    if (reg_addr == ADDR_W'(OFFS_SET_MASK))      sel = SEL_SET_MASK;
    else if (reg_addr == ADDR_W'(OFFS_CLR_MASK)) sel = SEL_CLR_MASK;
    else if (reg_addr == ADDR_W'(OFFS_MASK_RD))  sel = SEL_MASK_RD;
    else if (reg_addr == ADDR_W'(OFFS_STATUS))   sel = SEL_STATUS;
    else                                         sel = SEL_NONE;
  end

  assign set_mask_bits = (reg_wr && sel == SEL_SET_MASK) ? wbits : '0;
  assign clr_mask_bits = (reg_wr && sel == SEL_CLR_MASK) ? wbits : '0;
  assign clr_stat_bits = (reg_wr && sel == SEL_STATUS)   ? wbits : '0;

endmodule

// File: rtl/sirq_mask.sv
module sirq_mask #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_bits,
  input  logic [N_SRC-1:0] clr_bits,
  output logic [N_SRC-1:0] mask_q
);

  function automatic logic [N_SRC-1:0] mask_step(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] on_bits,
    input logic [N_SRC-1:0] off_bits
  );
    return (cur | on_bits) & ~off_bits;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_step(mask_q, set_bits, clr_bits);
  end

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((mask_q & $past(set_bits)) == $past(set_bits)));

  a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((mask_q & ~$past(set_bits)) == ($past(mask_q) & ~$past(set_bits))));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0) |=> ((mask_q & $past(clr_bits)) == '0));

  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == '0 && clr_bits == '0) |=> $stable(mask_q));

endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr_bits,
  output logic [N_SRC-1:0] stat_q
);

  function automatic logic stat_bit_step(input logic cur, input logic hit, input logic wipe);
    return hit | (cur & ~wipe);
  endfunction

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_bit_step(stat_q[i], evt[i], clr_bits[i]);
    end
  end

  // R5 and R7: an event always lands, even against a clear
  a_r5_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0) |=> ((stat_q & $past(clr_bits & ~evt)) == '0));

endmodule

// File: rtl/sirq_out.sv
module sirq_out #(
  parameter int unsigned N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] stat_q,
  input  logic [N_SRC-1:0] mask_q,
  output logic             irq
);

  logic [N_SRC-1:0] live;
  assign live = stat_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |live;
  end

  a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) != '0) |=> irq);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |=> !irq);

endmodule

// File: rtl/sirq_bank.sv
module sirq_bank
  import sirq_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_COUNT,
  parameter int unsigned ADDR_W = OFFS_W,
  parameter int unsigned DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  evt_pulse,
  output logic              irq
);

  reg_sel_e         sel;
  logic [N_SRC-1:0] set_mask_bits;
  logic [N_SRC-1:0] clr_mask_bits;
  logic [N_SRC-1:0] clr_stat_bits;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] stat_q;

  sirq_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .sel           (sel),
    .set_mask_bits (set_mask_bits),
    .clr_mask_bits (clr_mask_bits),
    .clr_stat_bits (clr_stat_bits)
  );

  sirq_mask #(.N_SRC(N_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_mask_bits),
    .clr_bits (clr_mask_bits),
    .mask_q   (mask_q)
  );

  sirq_status #(.N_SRC(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .clr_bits (clr_stat_bits),
    .stat_q   (stat_q)
  );

  sirq_out #(.N_SRC(N_SRC)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_q (stat_q),
    .mask_q (mask_q),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_MASK_RD: reg_rdata[N_SRC-1:0] = mask_q;
      SEL_STATUS:  reg_rdata[N_SRC-1:0] = stat_q;
      default:     reg_rdata = '0;
    endcase
  end

  // R4: upper read bits never carry data
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:N_SRC] == '0);

  // R1: the first cycle after reset shows an idle block
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && stat_q == '0 && !irq));

endmodule

// File: tb/sirq_bank_tb.sv
`timescale 1ns/1ps
module sirq_bank_tb;

  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [N-1:0] evt_pulse = '0;
  logic        irq;

  always #4 clk = ~clk;

  sirq_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq)
  );

  // reference model built from the requirements
  logic [N-1:0] mask_m, stat_m;
  logic         irq_m;
  always @(posedge clk) begin
    if (!rst_n) begin
      mask_m <= '0; stat_m <= '0; irq_m <= 1'b0;
    end else begin
      irq_m <= (stat_m & mask_m) != '0;
      if (reg_wr && reg_addr == 8'h08) mask_m <= mask_m | reg_wdata[N-1:0];
      if (reg_wr && reg_addr == 8'h0C) mask_m <= mask_m & ~reg_wdata[N-1:0];
      if (reg_wr && reg_addr == 8'h14) stat_m <= (stat_m & ~reg_wdata[N-1:0]) | evt_pulse;
      else                             stat_m <= stat_m | evt_pulse;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h10) return {19'b0, mask_m};
    if (a == 8'h14) return {19'b0, stat_m};
    return 32'h0;
  endfunction

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  probe;
  int    n_checks = 0;
  int    n_fail   = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(probe);
      #2;
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : reg_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; evt_pulse = '0;
    it.is_irq = 1'b0; it.exp = model_read(a); it.tag = tag;
    q.push_back(it);
    -> probe;
    #3;
  endtask

  task automatic chk_irq(input string tag);
    item_t it;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
    it.is_irq = 1'b1; it.exp = {31'b0, irq_m}; it.tag = tag;
    q.push_back(it);
    -> probe;
    #3;
  endtask

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [N-1:0] e);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; evt_pulse = e;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0; reg_wdata = 32'h0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk_rd(8'h10, "R1 mask after reset");
    chk_rd(8'h14, "R1 status after reset");
    chk_irq("R1 irq after reset");

    drive(1, 8'h08, 32'h0000_0005, '0);
    chk_rd(8'h10, "R2 set mask bits");
    if (model_read(8'h10) !== 32'h5) begin n_fail++; $display("FAIL R2 model mismatch actual=%h expected=%h", model_read(8'h10), 32'h5); end
    drive(1, 8'h08, 32'h0000_0100, '0);
    chk_rd(8'h10, "R2 other bits kept");
    drive(1, 8'h0C, 32'h0000_0001, '0);
    chk_rd(8'h10, "R3 clear mask bit");

    chk_rd(8'h08, "R4 set-mask offset reads zero");
    chk_rd(8'h0C, "R4 clear-mask offset reads zero");
    chk_rd(8'h30, "R4 unmapped reads zero");

    drive(1, 8'h10, 32'h0000_1FFF, '0);
    chk_rd(8'h10, "R9 write to mask offset ignored");
    drive(1, 8'h24, 32'h0000_1FFF, '0);
    chk_rd(8'h10, "R9 unmapped write mask");
    chk_rd(8'h14, "R9 unmapped write status");

    drive(0, 8'h00, 32'h0, 13'h0008);          // transmit empty while masked
    chk_rd(8'h14, "R5 masked event latches");
    chk_irq("R8 masked event no irq");
    idle(5);
    chk_rd(8'h14, "R5 sticky after idle");

    drive(1, 8'h08, 32'h0000_0008, '0);
    chk_irq("R8 irq raised after unmask");
    drive(1, 8'h14, 32'h0000_0008, '0);
    chk_rd(8'h14, "R6 status cleared");
    chk_irq("R8 irq dropped after clear");

    drive(1, 8'h08, 32'hFFFF_FFFF, 13'h1FFF);
    chk_rd(8'h10, "R4 R9 upper write bits ignored");
    chk_rd(8'h14, "R5 all sources latch");
    drive(1, 8'h14, 32'h0000_00F0, '0);
    chk_rd(8'h14, "R6 zeros keep other bits");

    drive(1, 8'h14, 32'h0000_0201, 13'h0200);  // set and clear collide on bit 9
    chk_rd(8'h14, "R7 set wins over clear");
    if (model_read(8'h14) !== 32'h1F0E) begin n_fail++; $display("FAIL R7 model mismatch actual=%h expected=%h", model_read(8'h14), 32'h1F0E); end
    chk_irq("R8 irq with live bits");

    drive(1, 8'h0C, 32'h0000_1FFF, '0);
    drive(1, 8'h14, 32'h0000_1FFF, '0);
    chk_rd(8'h10, "R3 quiesce mask");
    chk_rd(8'h14, "R6 quiesce status");
    chk_irq("R8 quiesce irq");

    idle(2);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule